// File: doc/BRIEF.md
# Serial Controller Interrupt Prioritizer and Identifier

This block sits beside the receive, transmit and modem-line logic of an asynchronous serial controller. It gathers their interrupt conditions into one request line. The conditions come from four classes: receive errors, received data (which includes a receive timeout in FIFO mode), transmit holding empty, and a change on a modem control line. Each class is masked by one bit of a 4-bit enable register. The block picks the most urgent enabled condition and returns it as an identification byte that software reads to learn the cause.

Each condition is held pending until its own register access clears it. An error clears when software reads line status. Received data clears when software reads the receive buffer. A modem line change clears when software reads modem status. Transmit holding empty clears when software writes the holding register. It also clears when software reads the identification byte while that byte names transmit empty. In FIFO mode the received-data condition follows the trigger-level flag directly, and a receive timeout condition becomes available. Shifters, FIFOs and the baud generator are outside the block; their status arrives on plain inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir_rdata` is 8'h01, `irq` is 0 and `ier_rdata` is 8'h00.
- R2: A write with `ier_we` stores `ier_wdata[3:0]` and reads back on `ier_rdata[3:0]` after the next edge. `ier_rdata[7:4]` always reads 0. Bit 0 enables received data and timeout, bit 1 enables transmit empty, bit 2 enables receive errors, and bit 3 enables modem change.
- R3: `iir_rdata[0]` is 0 exactly when an enabled condition is pending, and `irq` equals its inverse. When no condition is pending, `iir_rdata` is 8'h01. `iir_rdata[7:4]` is always 0.
- R4: When several enabled conditions are pending, `iir_rdata[3:1]` names the highest-ranked one. The ranking, with codes, is: receive error 3'b011, then received data 3'b010, then receive timeout 3'b110, then transmit empty 3'b001, then modem change 3'b000.
- R5: A pulse on `lsr_err_set` makes a receive error pending; it clears at the edge ending a cycle with `lsr_rd`. If both arrive in the same cycle, the new error stays pending.
- R6: Outside FIFO mode, a pulse on `rx_avail_set` makes received data pending, and a `rbr_rd` clears it. `rx_trig` has no effect outside FIFO mode.
- R7: In FIFO mode, received data is pending exactly while `rx_trig` is 1, and `rbr_rd` does not clear it.
- R8: In FIFO mode, a pulse on `rx_tmo_set` makes the timeout pending (code 3'b110), and `rbr_rd` clears it. Outside FIFO mode `rx_tmo_set` has no effect, so `iir_rdata[3]` stays 0.
- R9: Transmit empty becomes pending only on a 0-to-1 change of `thr_empty`; a level that stays 1 never raises it again. A `thr_wr` clears it. A `thr_empty` already at 1 when reset is released does not raise it.
- R10: An `iir_rd` clears transmit empty only when `iir_rdata` reads 8'h02 in that cycle. A read that reports a higher-ranked source leaves it pending.
- R11: A pulse on `msr_change` makes modem change pending, and an `msr_rd` clears it.
- R12: A condition latches whether or not it is enabled. A masked condition neither drives `irq` nor appears in `iir_rdata`. Enabling it later exposes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read value |
| fifo_mode | input | 1 | 1 selects FIFO mode |
| lsr_err_set | input | 1 | Pulse: overrun, parity, framing error or break seen |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_avail_set | input | 1 | Pulse: a character arrived (character mode) |
| rx_trig | input | 1 | Receive FIFO at or above trigger level |
| rx_tmo_set | input | 1 | Pulse: receive timeout detected |
| rbr_rd | input | 1 | Receive buffer read strobe |
| thr_empty | input | 1 | Transmit holding register empty level |
| thr_wr | input | 1 | Transmit holding register write strobe |
| msr_change | input | 1 | Pulse: a modem control line changed |
| msr_rd | input | 1 | Modem status register read strobe |
| iir_rd | input | 1 | Identification register read strobe |
| iir_rdata | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The clear-on-access checks assume that a strobe and the event that sets the same source do not meet in one cycle. The transmit-empty read check also assumes that `thr_empty` was already 1 in the cycle before the read, so a fresh rising edge cannot re-arm the source during the read. The stimulus changes one source per step and holds `thr_empty` steady around every identification read. Every pulse lasts one cycle, and each step is followed by a quiet cycle before the outputs are sampled.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  // pending-source indices, lowest index ranks highest
  localparam int unsigned SRC_LSR = 0;
  localparam int unsigned SRC_RXD = 1;
  localparam int unsigned SRC_TMO = 2;
  localparam int unsigned SRC_THR = 3;
  localparam int unsigned SRC_MSR = 4;
  localparam int unsigned NSRC    = 5;

  localparam int unsigned IER_W = 4;
  localparam int unsigned BUS_W = 8;

  typedef enum logic [2:0] {
    ID_MSR = 3'b000,
    ID_THR = 3'b001,
    ID_RXD = 3'b010,
    ID_LSR = 3'b011,
    ID_TMO = 3'b110
  } irq_id_e;

  function automatic irq_id_e src_code(input int unsigned idx);
    case (idx)
      SRC_LSR: return ID_LSR;
      SRC_RXD: return ID_RXD;
      SRC_TMO: return ID_TMO;
      SRC_THR: return ID_THR;
      default: return ID_MSR;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_ier.sv
`timescale 1ns/1ps
module uart_irq_ier
  import uart_irq_pkg::*;
#(
  parameter int unsigned EN_W  = IER_W,
  parameter int unsigned DAT_W = BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DAT_W-1:0] wdata,
  output logic [EN_W-1:0]  en,
  output logic [DAT_W-1:0] rdata
);
  localparam int unsigned PAD_W = DAT_W - EN_W;

  logic [EN_W-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (we) en_d = wdata[EN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en    = en_q;
  assign rdata = {{PAD_W{1'b0}}, en_q};
endmodule

// File: rtl/uart_irq_pend.sv
`timescale 1ns/1ps
module uart_irq_pend
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fifo_mode,
  input  logic            lsr_err_set,
  input  logic            lsr_rd,
  input  logic            rx_avail_set,
  input  logic            rx_trig,
  input  logic            rx_tmo_set,
  input  logic            rbr_rd,
  input  logic            thr_empty,
  input  logic            thr_wr,
  input  logic            thr_id_clr,
  input  logic            msr_change,
  input  logic            msr_rd,
  output logic [NSRC-1:0] pend
);
  logic lsr_q, lsr_d;
  logic rx_q, rx_d;
  logic tmo_q, tmo_d;
  logic thr_q, thr_d;
  logic lvl_q;
  logic msr_q, msr_d;
  logic thr_rise;

  always_comb begin
    thr_rise = thr_empty & ~lvl_q;
    lsr_d = lsr_err_set | (lsr_q & ~lsr_rd);
    rx_d  = ~fifo_mode & (rx_avail_set | (rx_q & ~rbr_rd));
    tmo_d = fifo_mode & (rx_tmo_set | (tmo_q & ~rbr_rd));
    thr_d = thr_rise | (thr_q & ~thr_wr & ~thr_id_clr);
    msr_d = msr_change | (msr_q & ~msr_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsr_q <= 1'b0;
      rx_q  <= 1'b0;
      tmo_q <= 1'b0;
      thr_q <= 1'b0;
      lvl_q <= 1'b1;
      msr_q <= 1'b0;
    end else begin
      lsr_q <= lsr_d;
      rx_q  <= rx_d;
      tmo_q <= tmo_d;
      thr_q <= thr_d;
      lvl_q <= thr_empty;
      msr_q <= msr_d;
    end
  end

  always_comb begin
    pend          = '0;
    pend[SRC_LSR] = lsr_q;
    pend[SRC_RXD] = fifo_mode ? rx_trig : rx_q;
    pend[SRC_TMO] = tmo_q;
    pend[SRC_THR] = thr_q;
    pend[SRC_MSR] = msr_q;
  end
endmodule

// File: rtl/uart_irq_prio.sv
`timescale 1ns/1ps
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] act,
  output logic [3:0]      id
);
  always_comb begin
    id = 4'b0001;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i]) id = {src_code(i), 1'b0};
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_we,
  input  logic [7:0] ier_wdata,
  output logic [7:0] ier_rdata,
  input  logic       fifo_mode,
  input  logic       lsr_err_set,
  input  logic       lsr_rd,
  input  logic       rx_avail_set,
  input  logic       rx_trig,
  input  logic       rx_tmo_set,
  input  logic       rbr_rd,
  input  logic       thr_empty,
  input  logic       thr_wr,
  input  logic       msr_change,
  input  logic       msr_rd,
  input  logic       iir_rd,
  output logic [7:0] iir_rdata,
  output logic       irq
);
  logic [IER_W-1:0] en;
  logic [NSRC-1:0]  pend, en_map, act;
  logic [3:0]       id;
  logic             thr_id_clr;

  uart_irq_ier #(.EN_W(IER_W), .DAT_W(BUS_W)) u_ier (
    .clk(clk), .rst_n(rst_n), .we(ier_we), .wdata(ier_wdata),
    .en(en), .rdata(ier_rdata)
  );

  uart_irq_pend u_pend (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .lsr_err_set(lsr_err_set), .lsr_rd(lsr_rd),
    .rx_avail_set(rx_avail_set), .rx_trig(rx_trig),
    .rx_tmo_set(rx_tmo_set), .rbr_rd(rbr_rd),
    .thr_empty(thr_empty), .thr_wr(thr_wr), .thr_id_clr(thr_id_clr),
    .msr_change(msr_change), .msr_rd(msr_rd), .pend(pend)
  );

  // enable bit per source: data/timeout share bit 0
  always_comb begin
    en_map          = '0;
    en_map[SRC_LSR] = en[2];
    en_map[SRC_RXD] = en[0];
    en_map[SRC_TMO] = en[0];
    en_map[SRC_THR] = en[1];
    en_map[SRC_MSR] = en[3];
  end

  assign act = pend & en_map;

  uart_irq_prio u_prio (.act(act), .id(id));

  // the value on the bus during the read strobe decides the clear
  assign thr_id_clr = iir_rd & (id == {ID_THR, 1'b0});
  assign iir_rdata  = {4'b0000, id};
  assign irq        = |act;
endmodule

// File: rtl/uart_irq_ident_chk.sv
`timescale 1ns/1ps
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_we,
  input logic [7:0] ier_wdata,
  input logic [7:0] ier_rdata,
  input logic       fifo_mode,
  input logic       lsr_err_set,
  input logic       lsr_rd,
  input logic       msr_change,
  input logic       msr_rd,
  input logic       thr_empty,
  input logic       iir_rd,
  input logic [7:0] iir_rdata,
  input logic       irq
);
  // R3
  irq_id_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !iir_rdata[0]);

  // R8
  no_id2_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !iir_rdata[3]);

  // R2
  ier_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ier_we |=> ier_rdata[3:0] == $past(ier_wdata[3:0]));

  // R12
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ier_rdata[3:0] == 4'h0 |-> !irq);

  // R5
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !lsr_err_set |=> iir_rdata[3:0] != 4'b0110);

  // R11
  msr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msr_rd && !msr_change |=> iir_rdata[3:0] != 4'b0000);

  // R10
  thr_id_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rd && iir_rdata[3:0] == 4'b0010 && $past(thr_empty) |=> iir_rdata[3:0] != 4'b0010);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ier_we;
  logic [7:0] ier_wdata;
  logic [7:0] ier_rdata;
  logic       fifo_mode, lsr_err_set, lsr_rd, rx_avail_set, rx_trig;
  logic       rx_tmo_set, rbr_rd, thr_empty, thr_wr, msr_change, msr_rd, iir_rd;
  logic [7:0] iir_rdata;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (.*);

  // {ier[3:0], fifo lsr rx trig | tmo thre msr lsr_rd | rbr_rd iir_rd thr_wr msr_rd, exp_id[3:0]}
  localparam int NV = 25;
  localparam logic [19:0] VEC [NV] = '{
    {4'hF, 12'b0000_0000_0000, 4'b0001},
    {4'hF, 12'b0000_0010_0000, 4'b0000},
    {4'hF, 12'b0000_0100_0000, 4'b0010},
    {4'hF, 12'b0010_0100_0000, 4'b0100},
    {4'hF, 12'b0100_0100_0000, 4'b0110},
    {4'hF, 12'b0000_0100_0100, 4'b0110},
    {4'hF, 12'b0000_0101_0000, 4'b0100},
    {4'hF, 12'b0000_0100_1000, 4'b0010},
    {4'hF, 12'b0000_0100_0100, 4'b0000},
    {4'hF, 12'b0000_0100_0000, 4'b0000},
    {4'hF, 12'b0000_0100_0001, 4'b0001},
    {4'hF, 12'b0000_0000_0000, 4'b0001},
    {4'hF, 12'b0000_0100_0000, 4'b0010},
    {4'hF, 12'b0000_0100_0010, 4'b0001},
    {4'h0, 12'b0000_0010_0000, 4'b0001},
    {4'h8, 12'b0000_0000_0000, 4'b0000},
    {4'h8, 12'b0000_0000_0001, 4'b0001},
    {4'h1, 12'b1001_0000_0000, 4'b0100},
    {4'h1, 12'b1000_1000_0000, 4'b1100},
    {4'h1, 12'b1000_0000_1000, 4'b0001},
    {4'h1, 12'b1001_0000_1000, 4'b0100},
    {4'h1, 12'b0001_0000_0000, 4'b0001},
    {4'h1, 12'b0000_1000_0000, 4'b0001},
    {4'h4, 12'b0100_0001_0000, 4'b0110},
    {4'h4, 12'b0000_0001_0000, 4'b0001}
  };

  function automatic string vtag(input int i);
    case (i)
      0:  return "R3 idle";
      1:  return "R11 modem set";
      2:  return "R4/R9 transmit over modem";
      3:  return "R4/R6 data over transmit";
      4:  return "R4/R5 error ranks highest";
      5:  return "R10 read of error id keeps transmit";
      6:  return "R5 line status read";
      7:  return "R6/R10 buffer read, transmit kept";
      8:  return "R10 id read clears transmit";
      9:  return "R9 no re-raise on steady empty";
      10: return "R11 modem read clears";
      11: return "R9 falling edge no effect";
      12: return "R9 rising edge re-arms";
      13: return "R9 holding write clears";
      14: return "R12 masked modem change";
      15: return "R12 enabling exposes latched";
      16: return "R11 modem read clears again";
      17: return "R7 trigger level";
      18: return "R8 timeout code";
      19: return "R8 buffer read clears timeout";
      20: return "R7 buffer read does not clear level";
      21: return "R6 trigger ignored in character mode";
      22: return "R8 timeout ignored in character mode";
      23: return "R5 set wins over read";
      24: return "R5 line status read clears";
      default: return "R3";
    endcase
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    ier_we = 0; ier_wdata = 8'h00; lsr_err_set = 0; lsr_rd = 0; rx_avail_set = 0;
    rx_tmo_set = 0; rbr_rd = 0; thr_wr = 0; msr_change = 0; msr_rd = 0; iir_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic apply(input logic [19:0] v);
    @(negedge clk);
    ier_we = 1'b1; ier_wdata = {4'h0, v[19:16]};
    fifo_mode = v[15]; lsr_err_set = v[14]; rx_avail_set = v[13]; rx_trig = v[12];
    rx_tmo_set = v[11]; thr_empty = v[10]; msr_change = v[9]; lsr_rd = v[8];
    rbr_rd = v[7]; iir_rd = v[6]; thr_wr = v[5]; msr_rd = v[4];
    @(negedge clk);
    quiet();
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    quiet();
    fifo_mode = 0; rx_trig = 0; thr_empty = 0;
    do_reset();
    #1;
    // R1 reset state
    check8("R1 iir after reset", iir_rdata, 8'h01);
    check8("R1 irq after reset", {7'b0, irq}, 8'h00);
    check8("R1 ier after reset", ier_rdata, 8'h00);

    // R2 upper enable bits read zero
    @(negedge clk);
    ier_we = 1'b1; ier_wdata = 8'hFF;
    @(negedge clk);
    quiet();
    #1;
    check8("R2 enable readback", ier_rdata, 8'h0F);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check8(vtag(i), iir_rdata, {4'h0, VEC[i][3:0]});
      check8({vtag(i), " irq (R3)"}, {7'b0, irq}, {7'b0, ~VEC[i][0]});
    end

    // R9 empty held through reset does not raise transmit empty
    thr_empty = 1'b1;
    fifo_mode = 1'b0; rx_trig = 1'b0;
    do_reset();
    apply({4'hF, 12'b0000_0100_0000, 4'b0000});
    check8("R9 empty across reset", iir_rdata, 8'h01);
    apply({4'hF, 12'b0000_0000_0000, 4'b0000});
    apply({4'hF, 12'b0000_0100_0000, 4'b0000});
    check8("R9 first rise after reset", iir_rdata, 8'h02);

    // R12 transmit empty masked, then exposed
    apply({4'h0, 12'b0000_0100_0000, 4'b0000});
    check8("R12 masked transmit irq", {7'b0, irq}, 8'h00);
    apply({4'h2, 12'b0000_0100_0000, 4'b0000});
    check8("R12 unmasked transmit", iir_rdata, 8'h02);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule